// File: doc/BRIEF.md
# Instruction-Controlled Boundary-Scan Register

This block is a chain of boundary-scan cells that sits between a chip's system pins and its core logic. There are two kinds of cell, and the number of each is set by a parameter. An input cell sits on a path from a pin to the core. An output cell sits on a path from the core to a pin. Every cell has two stages: a scan stage, which captures and shifts, and a parallel update latch behind it.

The test-access state machine and the instruction register are outside the block. They supply a two-bit instruction select and three state strobes: capture, shift and update. The instruction decides three things:
- which value each cell captures,
- whether the pins and the core see their live system signals or the update latches,
- whether the output latches may change at all.

The sample-and-preload instruction is normally used first. It captures a snapshot of the system traffic and at the same time loads the update latches with a safe pattern. A later switch to the external-test instruction then drives known data onto the board as soon as it takes effect. The self-test instruction holds the output pins frozen at the values already preloaded.

Top module: `bscan_chain`

## Requirements
- R1: The instruction select is `instr`, coded as follows: 0 = sample/preload, 1 = external test, 2 = internal test, 3 = self-test. The scan path runs from `tdi` through input cells 0 to N_IN-1, then through output cells 0 to N_OUT-1, and ends at `tdo`. While `shift_en` is high, each rising `tck` edge moves the data one cell along the path. `tdo` is the last output cell's scan stage, registered on the falling `tck` edge.
- R2: While `capture_en` is high, every scan stage loads its capture value on the rising `tck` edge. If both strobes are high, capture takes priority over shift.
- R3: Under sample/preload, `pin_out` equals `core_out` and `core_in` equals `pin_in` at all times, including while scanning and updating.
- R4: Under sample/preload, an input cell captures its `pin_in` bit and an output cell captures its `core_out` bit.
- R5: Update latches load from their scan stages only on a falling `tck` edge while `update_en` is high. They hold at every other time.
- R6: Under external test, `pin_out` is driven from the output latches. An input cell captures its `pin_in` bit. An output cell captures its own latch, so the captured value does not depend on `core_out`.
- R7: Under internal test, `core_in` is driven from the input latches and `pin_out` from the output latches. An output cell captures `core_out`. An input cell captures its own latch, so the captured value does not depend on `pin_in`.
- R8: Under self-test, `pin_out` and `core_in` are driven from the latches. The output latches do not change even when `update_en` is high, while the input latches still update. Capture sources are the same as in R7.
- R9: While `trst_n` is low, the scan stages, the latches and `tdo` are all zero, and both directions pass through as in R3, whatever the instruction.
- R10: In a single scan, the data captured earlier shifts out on `tdo` while the new preload data shifts in from `tdi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial scan input |
| capture_en | input | 1 | Capture state strobe |
| shift_en | input | 1 | Shift state strobe |
| update_en | input | 1 | Update state strobe |
| instr | input | 2 | Decoded current instruction |
| pin_in | input | N_IN | Values arriving at the input pins |
| core_in | output | N_IN | Values delivered to the core logic |
| core_out | input | N_OUT | Values produced by the core logic |
| pin_out | output | N_OUT | Values driven onto the output pins |
| tdo | output | 1 | Serial scan output |

## Verification
The bench preloads under sample/preload and then switches to external test. A design that updated the output latches too late, or that gated the pin drive badly, would show live core values on the pins instead of the preload pattern. Under external test the bench keeps `core_out` changing through each capture, and under internal test it keeps `pin_in` changing. A design that captured from the wrong side would then shift out data that depends on off-chip or core traffic. Under self-test the bench pulses the update strobe with new data in the chain; an output latch that was not frozen would move the pins. The bench also raises capture and shift together to check capture priority, and it pulls reset low between clock edges to check that the latches clear and the pass-through takes over at once.

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tdi,
  input  logic             capture_en,
  input  logic             shift_en,
  input  logic             update_en,
  input  logic [1:0]       instr,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] pin_out,
  output logic             tdo
);
  localparam int LEN = N_IN + N_OUT;
  localparam logic [1:0] I_SAMPLE = 2'd0;
  localparam logic [1:0] I_EXT    = 2'd1;
  localparam logic [1:0] I_INT    = 2'd2;
  localparam logic [1:0] I_BIST   = 2'd3;

  logic [LEN-1:0]   scan_q;
  logic [N_IN-1:0]  lat_in;
  logic [N_OUT-1:0] lat_out;
  logic             to_core_from_lat, to_pin_from_lat;
  logic [N_IN-1:0]  grab_in;
  logic [N_OUT-1:0] grab_out;

  assign to_pin_from_lat  = trst_n && (instr != I_SAMPLE);
  assign to_core_from_lat = trst_n && (instr == I_INT || instr == I_BIST);

  assign pin_out = to_pin_from_lat  ? lat_out : core_out;
  assign core_in = to_core_from_lat ? lat_in  : pin_in;

  assign grab_in  = (instr == I_INT || instr == I_BIST) ? lat_in : pin_in;
  assign grab_out = (instr == I_EXT) ? lat_out : core_out;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)
      scan_q <= '0;
    else if (capture_en)
      scan_q <= {grab_out, grab_in};
    else if (shift_en)
      scan_q <= {scan_q[LEN-2:0], tdi};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo     <= 1'b0;
      lat_in  <= '0;
      lat_out <= '0;
    end else begin
      tdo <= scan_q[LEN-1];
      if (update_en) begin
        lat_in <= scan_q[N_IN-1:0];
        if (instr != I_BIST)
          lat_out <= scan_q[LEN-1:N_IN];
      end
    end
  end

  assert_shift_entry_R1: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_en && !capture_en) |=> scan_q[0] == $past(tdi));

  assert_sample_pass_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (instr == I_SAMPLE) |-> (pin_out == core_out && core_in == pin_in));

  assert_latch_hold_R5: assert property (@(negedge tck) disable iff (!trst_n)
    !update_en |=> $stable(lat_in));

  assert_ext_capture_R6: assert property (@(posedge tck) disable iff (!trst_n)
    (capture_en && instr == I_EXT) |=> scan_q[LEN-1:N_IN] == $past(lat_out));

  assert_bist_freeze_R8: assert property (@(posedge tck) disable iff (!trst_n)
    (instr == I_BIST && $past(instr) == I_BIST) |-> $stable(pin_out));
endmodule

// File: tb/bscan_chain_bench.sv
module bscan_chain_bench;
  localparam int N_IN  = 4;
  localparam int N_OUT = 4;
  localparam int LEN   = N_IN + N_OUT;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tdi = 1'b0, capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0;
  logic [1:0] instr = 2'd0;
  logic [N_IN-1:0]  pin_in = '0;
  logic [N_OUT-1:0] core_out = '0;
  logic [N_IN-1:0]  core_in;
  logic [N_OUT-1:0] pin_out;
  logic tdo;

  int total = 0, bad = 0;
  string cur_req = "R9";
  bit done = 0;

  always #10 tck = ~tck;

  bscan_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) u_bscan_chain (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_en(capture_en),
    .shift_en(shift_en), .update_en(update_en), .instr(instr),
    .pin_in(pin_in), .core_in(core_in), .core_out(core_out),
    .pin_out(pin_out), .tdo(tdo));

  // reference model: queue index 0 is the cell nearest tdi
  bit q[$];
  bit m_lin[N_IN];
  bit m_lout[N_OUT];
  bit m_tdo = 0;

  initial for (int k = 0; k < LEN; k++) q.push_back(1'b0);

  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      for (int k = 0; k < LEN; k++) q[k] = 1'b0;
    end else if (capture_en) begin
      for (int k = 0; k < N_IN; k++)
        q[k] = (instr >= 2) ? m_lin[k] : pin_in[k];
      for (int k = 0; k < N_OUT; k++)
        q[N_IN+k] = (instr == 1) ? m_lout[k] : core_out[k];
    end else if (shift_en) begin
      q.push_front(tdi);
      void'(q.pop_back());
    end
  end

  always @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      m_tdo = 0;
      for (int k = 0; k < N_IN; k++) m_lin[k] = 0;
      for (int k = 0; k < N_OUT; k++) m_lout[k] = 0;
    end else begin
      m_tdo = q[LEN-1];
      if (update_en) begin
        for (int k = 0; k < N_IN; k++) m_lin[k] = q[k];
        if (instr != 3)
          for (int k = 0; k < N_OUT; k++) m_lout[k] = q[N_IN+k];
      end
    end
  end

  function automatic logic [N_OUT-1:0] exp_pins();
    logic [N_OUT-1:0] v;
    for (int k = 0; k < N_OUT; k++) v[k] = (trst_n && instr != 0) ? m_lout[k] : core_out[k];
    return v;
  endfunction

  function automatic logic [N_IN-1:0] exp_core();
    logic [N_IN-1:0] v;
    for (int k = 0; k < N_IN; k++) v[k] = (trst_n && instr >= 2) ? m_lin[k] : pin_in[k];
    return v;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(cur_req, "tdo", 32'(tdo), 32'(m_tdo));
    check(cur_req, "pin_out", 32'(pin_out), 32'(exp_pins()));
    check(cur_req, "core_in", 32'(core_in), 32'(exp_core()));
  endtask

  always @(negedge tck) begin
    #2;
    if (!done) compare_all();
  end

  task automatic cyc(bit c, bit s, bit u, bit d);
    @(negedge tck); #5;
    capture_en = c; shift_en = s; update_en = u; tdi = d;
  endtask

  task automatic jiggle();
    pin_in = N_IN'($urandom);
    core_out = N_OUT'($urandom);
  endtask

  task automatic scan(logic [LEN-1:0] pat, bit wiggle);
    cyc(1, 0, 0, 0);
    for (int k = 0; k < LEN; k++) begin
      cyc(0, 1, 0, pat[k]);
      if (wiggle) jiggle();
    end
    cyc(0, 0, 1, 0);
    if (wiggle) jiggle();
    cyc(0, 0, 0, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    jiggle();
    repeat (3) @(negedge tck);
    #5;
    check("R9", "tdo in reset", 32'(tdo), 32'd0);
    check("R9", "pins pass in reset", 32'(pin_out), 32'(core_out));
    instr = 2'd2;
    #1;
    check("R9", "core pass in reset", 32'(core_in), 32'(pin_in));
    instr = 2'd0;
    trst_n = 1'b1;

    cur_req = "R3";
    repeat (4) begin cyc(0, 0, 0, 0); jiggle(); end

    cur_req = "R4";
    scan(8'hA5, 1);
    cur_req = "R10";
    scan(8'h3C, 1);
    check("R3", "pins still pass after preload", 32'(pin_out), 32'(core_out));

    cur_req = "R6";
    @(negedge tck); #5; instr = 2'd1;
    #1;
    begin
      logic [N_OUT-1:0] want;
      for (int k = 0; k < N_OUT; k++) want[k] = 1'(8'h3C >> (LEN - 1 - (N_IN + k)));
      check("R6", "preload on pins", 32'(pin_out), 32'(want));
    end
    scan(8'h96, 1);
    scan(8'h0F, 1);

    cur_req = "R5";
    for (int k = 0; k < LEN; k++) cyc(0, 1, 0, 1'(k));
    repeat (3) cyc(0, 0, 0, 0);

    cur_req = "R7";
    @(negedge tck); #5; instr = 2'd2;
    scan(8'h5A, 1);
    scan(8'hC3, 1);

    cur_req = "R8";
    @(negedge tck); #5; instr = 2'd3;
    begin
      logic [N_OUT-1:0] held;
      held = pin_out;
      scan(8'hFF, 1);
      scan(8'h00, 1);
      check("R8", "pins frozen", 32'(pin_out), 32'(held));
    end

    cur_req = "R2";
    @(negedge tck); #5; instr = 2'd0;
    jiggle();
    cyc(1, 1, 0, 1);
    for (int k = 0; k < LEN; k++) cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 0);

    cur_req = "R1";
    @(negedge tck); #5; instr = 2'd1;
    scan(8'h81, 0);
    scan(8'h7E, 0);

    cur_req = "R9";
    @(negedge tck); #8;
    trst_n = 1'b0;
    #1;
    check("R9", "async clear pins", 32'(pin_out), 32'(core_out));
    check("R9", "async clear tdo", 32'(tdo), 32'd0);
    repeat (2) @(negedge tck);
    #5; trst_n = 1'b1;
    repeat (2) cyc(0, 0, 0, 0);
    check("R9", "latches cleared", 32'(pin_out), 32'd0);
    @(negedge tck); #3;
    finish_run();
  end
endmodule